// File: doc/BRIEF.md
# Character Display Start-Up and Character Sequencer

This block chooses what a character display bus engine transfers next. Each time reset is released, it walks through a fixed list of four configuration commands. The bus engine reports each completed poll-and-write cycle with a one-cycle done pulse. After the last command, the block switches to character mode.

In character mode the block tells the engine to wait in its write-setup stage. It stays there until a one-cycle write strobe arrives. The strobe normally comes from a conditioned push-button pulse. On that strobe the block captures the 8-bit character input and releases the engine. It keeps the captured byte steady until the engine reports the transfer complete.

Reset is synchronous and active low. Any inversion of a physical button happens outside the block.

Top module: `lcd_init_seq`

## Requirements
- R1: In the first cycle after reset, the outputs are: `rs`=0, `data_out`=0x01 and `go`=1.
- R2: Commands are issued with `rs`=0 in this order: 0x01, 0x33, 0x0C, 0x06. Each `xfer_done` pulse moves to the next command, and the new byte is visible in the cycle after the pulse.
- R3: While no `xfer_done` pulse arrives, the current command byte, `rs` and `go` do not change.
- R4: The done pulse that completes command 0x06 switches the block to character mode. From the next cycle, `rs`=1 and `go`=0 (hold).
- R5: In character mode with `go`=0, a `wr_stb` pulse captures `char_in`. From the next cycle, `data_out` shows that byte and `go`=1. An `xfer_done` pulse in the same cycle as the strobe does not prevent the capture.
- R6: While a character is pending (`go`=1, `rs`=1), `data_out` stays at the captured byte. This holds even if `char_in` changes or further strobes arrive.
- R7: The `xfer_done` pulse for a pending character drops `go` to 0 in the next cycle. `data_out` keeps the last character, and a strobe in that same cycle is ignored.
- R8: Strobes during the command phase have no effect on the command order or the bytes sent.
- R9: An `xfer_done` pulse while holding for a strobe has no effect: `go` stays 0 and `data_out` is unchanged.
- R10: Asserting reset at any point restarts the command list from 0x01 with `rs`=0. The captured character is cleared to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_stb | input | 1 | One-cycle request to send `char_in` |
| char_in | input | 8 | Character byte to send |
| xfer_done | input | 1 | One-cycle pulse: the bus engine finished a poll-and-write cycle |
| rs | output | 1 | Register select: 0 = command, 1 = character |
| data_out | output | 8 | Byte for the engine to write |
| go | output | 1 | 1 = engine may perform the write; 0 = hold in write setup |

## Verification
The bench targets the cycles where two events meet. A strobe that coincides with a done pulse while holding must still capture the character; a design that checks done first would lose the keypress. A strobe that coincides with the done pulse that completes a character must be dropped; a design that accepts it would skip the hold and resend without a fresh press. Strobes during start-up must leave the command list untouched; a design that reacted to them would jump to character mode early. A done pulse while holding must not release the engine; a design that reacted to it would send the old byte twice. A reset in mid-stream must restart from the clear command, which catches a sequencer that only rewinds at power-up.

// File: rtl/lcd_seq_pkg.sv
// Package: shared types and the start-up command list for the sequencer.
// Assumes: the list length is fixed by the display's start-up procedure.
package lcd_seq_pkg;
    localparam int BYTE_W   = 8;
    localparam int INIT_LEN = 4;
    localparam int IDX_W    = $clog2(INIT_LEN);

    typedef enum logic [1:0] {
        PH_INIT = 2'd0,   // issuing start-up commands
        PH_HOLD = 2'd1,   // character mode, waiting for a strobe
        PH_SEND = 2'd2    // character mode, character pending
    } phase_t;

    // Returns the start-up command for a given position in the list.
    function automatic logic [BYTE_W-1:0] init_byte(input logic [IDX_W-1:0] idx);
        case (idx)
            2'd0:    init_byte = 8'h01;  // clear screen
            2'd1:    init_byte = 8'h33;  // interface and font setup
            2'd2:    init_byte = 8'h0C;  // display on, cursor off
            default: init_byte = 8'h06;  // cursor advance mode
        endcase
    endfunction
endpackage

// File: rtl/lcd_init_rom.sv
// Module: start-up command lookup.
// Maps the command index to its byte. Purely combinational; the index comes
// from the phase controller and is only meaningful during the command phase.
module lcd_init_rom
    import lcd_seq_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] cmd
);
    // Look up the command byte for the current step.
    always_comb begin
        cmd = init_byte(idx);
    end
endmodule

// File: rtl/lcd_char_latch.sv
// Module: character capture register.
// Loads the input byte when told to by the controller and otherwise holds it.
// Assumes the load request is already qualified (only when holding for a key).
module lcd_char_latch
    import lcd_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] q
);
    // Capture register; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din;
    end

    // R6: the byte only changes on a qualified load.
    a_r6_char_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/lcd_phase_ctrl.sv
// Module: phase and step controller.
// Counts start-up commands on done pulses, then alternates between holding
// for a strobe and waiting for the pending character to complete.
// Assumes wr_stb and xfer_done are single-cycle pulses in the clk domain.
module lcd_phase_ctrl
    import lcd_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic             xfer_done,
    output phase_t           phase,
    output logic [IDX_W-1:0] idx,
    output logic             load
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(INIT_LEN - 1);

    phase_t phase_nx;
    logic [IDX_W-1:0] idx_nx;

    // Capture only while holding for a key.
    assign load = (phase == PH_HOLD) && wr_stb;

    // Next-state logic for phase and command index.
    always_comb begin
        phase_nx = phase;
        idx_nx   = idx;
        case (phase)
            PH_INIT: if (xfer_done) begin
                if (idx == LAST_IDX) phase_nx = PH_HOLD;
                else                 idx_nx   = idx + 1'b1;
            end
            PH_HOLD: if (wr_stb)    phase_nx = PH_SEND;
            PH_SEND: if (xfer_done) phase_nx = PH_HOLD;
            default:                phase_nx = PH_INIT;
        endcase
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_INIT;
            idx   <= '0;
        end else begin
            phase <= phase_nx;
            idx   <= idx_nx;
        end
    end

    // R3: no done pulse, no advance during start-up.
    a_r3_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INIT && !xfer_done) |=> ($stable(idx) && phase == PH_INIT));
    // R4: last command done enters character hold.
    a_r4_enter_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INIT && idx == LAST_IDX && xfer_done) |=> phase == PH_HOLD);
    // R7: completion of a pending character returns to hold.
    a_r7_back_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SEND && xfer_done) |=> phase == PH_HOLD);
    // R9: done while holding does not release.
    a_r9_hold_ignores_done: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD && !wr_stb) |=> phase == PH_HOLD);
endmodule

// File: rtl/lcd_init_seq.sv
// Module: top of the start-up and character sequencer.
// Drives rs, the byte and the go/hold flag for a separate bus engine.
// Assumes the engine pulses xfer_done once per finished poll-and-write cycle
// and stalls in its write setup while go is low.
module lcd_init_seq
    import lcd_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] char_in,
    input  logic              xfer_done,
    output logic              rs,
    output logic [BYTE_W-1:0] data_out,
    output logic              go
);
    phase_t            phase;
    logic [IDX_W-1:0]  idx;
    logic              load;
    logic [BYTE_W-1:0] cmd_byte;
    logic [BYTE_W-1:0] char_byte;

    lcd_phase_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .xfer_done(xfer_done),
        .phase(phase), .idx(idx), .load(load)
    );

    lcd_init_rom i_rom (.idx(idx), .cmd(cmd_byte));

    lcd_char_latch i_latch (
        .clk(clk), .rst_n(rst_n), .load(load), .din(char_in), .q(char_byte)
    );

    // Output selection: commands during start-up, captured byte afterwards.
    always_comb begin
        rs       = (phase != PH_INIT);
        go       = (phase != PH_HOLD);
        data_out = rs ? char_byte : cmd_byte;
    end

    // R1 / R10: after reset the clear command is presented.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (rs == 1'b0 && data_out == 8'h01 && go == 1'b1));
    // R4: holding only ever happens in character mode.
    a_r4_hold_is_char: assert property (@(posedge clk) disable iff (!rst_n)
        !go |-> rs);
    // R5: a strobe while holding releases the engine next cycle.
    a_r5_strobe_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && wr_stb) |=> (go && rs));
    // R6: a pending character's byte stays put until done.
    a_r6_pending_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (go && rs && !xfer_done) |=> ($stable(data_out) && go));
endmodule

// File: tb/test_lcd_init_seq.sv
module test_lcd_init_seq;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_stb;
    logic [7:0] char_in;
    logic       xfer_done;
    logic       rs;
    logic [7:0] data_out;
    logic       go;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    lcd_init_seq i_lcd_init_seq (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .char_in(char_in),
        .xfer_done(xfer_done), .rs(rs), .data_out(data_out), .go(go)
    );

    // Vector: {req[3:0], done, stb, char[7:0], exp_rs, exp_data[7:0], exp_go}
    localparam int NV = 14;
    localparam logic [23:0] VEC [NV] = '{
        {4'd3,  1'b0, 1'b0, 8'h00, 1'b0, 8'h01, 1'b1}, // R3 idle keeps 0x01
        {4'd8,  1'b0, 1'b1, 8'hAA, 1'b0, 8'h01, 1'b1}, // R8 strobe ignored
        {4'd2,  1'b1, 1'b0, 8'h00, 1'b0, 8'h33, 1'b1}, // R2 second command
        {4'd2,  1'b1, 1'b0, 8'h00, 1'b0, 8'h0C, 1'b1}, // R2 third command
        {4'd8,  1'b0, 1'b1, 8'h55, 1'b0, 8'h0C, 1'b1}, // R8 strobe ignored
        {4'd2,  1'b1, 1'b0, 8'h00, 1'b0, 8'h06, 1'b1}, // R2 fourth command
        {4'd4,  1'b1, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0}, // R4 enter hold
        {4'd9,  1'b1, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0}, // R9 done ignored
        {4'd5,  1'b0, 1'b1, 8'h41, 1'b1, 8'h41, 1'b1}, // R5 capture
        {4'd6,  1'b0, 1'b1, 8'h42, 1'b1, 8'h41, 1'b1}, // R6 extra strobe
        {4'd6,  1'b0, 1'b0, 8'h43, 1'b1, 8'h41, 1'b1}, // R6 input change
        {4'd7,  1'b1, 1'b0, 8'h00, 1'b1, 8'h41, 1'b0}, // R7 complete
        {4'd5,  1'b1, 1'b1, 8'hFF, 1'b1, 8'hFF, 1'b1}, // R5 strobe+done in hold
        {4'd7,  1'b1, 1'b1, 8'h10, 1'b1, 8'hFF, 1'b0}  // R7 strobe on completion
    };

    task automatic check(input int req, input logic e_rs, input logic [7:0] e_d,
                         input logic e_go);
        checks++;
        if (rs !== e_rs || data_out !== e_d || go !== e_go) begin
            fails++;
            $display("FAIL R%0d: got rs=%b data=%h go=%b, expected rs=%b data=%h go=%b",
                     req, rs, data_out, go, e_rs, e_d, e_go);
        end
    endtask

    // Drive one cycle of inputs at negedge, check at the following negedge.
    task automatic step(input logic d, input logic s, input logic [7:0] c);
        xfer_done = d; wr_stb = s; char_in = c;
        @(negedge clk);
        xfer_done = 1'b0; wr_stb = 1'b0;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: got hang, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_stb = 1'b0; xfer_done = 1'b0; char_in = 8'h00;
        @(negedge clk); @(negedge clk);
        check(1, 1'b0, 8'h01, 1'b1); // R1 reset state
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][19], VEC[i][18], VEC[i][17:10]);
            check(int'(VEC[i][23:20]), VEC[i][9], VEC[i][8:1], VEC[i][0]);
        end
        // R9 again: idle hold keeps last byte
        step(1'b1, 1'b0, 8'h77);
        check(9, 1'b1, 8'hFF, 1'b0);
        // R10: reset mid-stream with a character pending
        step(1'b0, 1'b1, 8'h3C);
        check(5, 1'b1, 8'h3C, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check(10, 1'b0, 8'h01, 1'b1); // R10 replay from clear
        rst_n = 1'b1;
        step(1'b1, 1'b0, 8'h00);
        check(10, 1'b0, 8'h33, 1'b1); // R10 sequence restarts
        step(1'b1, 1'b0, 8'h00);
        step(1'b1, 1'b0, 8'h00);
        step(1'b1, 1'b0, 8'h00);
        check(10, 1'b1, 8'h00, 1'b0); // R10 captured byte cleared
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule